// File: doc/BRIEF.md
# Non-Volatile Write/Erase Unlock Sequencer

This block stands between software and the program/erase controller of an on-chip non-volatile memory. Software must write two specific bytes, 0xA5 and then 0xF1, to a key register before a program or erase may start. The block is fed a decoded key-register write strobe with its data byte and an "operation attempted" strobe from the program/erase controller. It answers with a level that says whether an operation is currently permitted, a one-cycle start pulse for an accepted attempt, a sticky lockout flag and a two-bit status code that the register bank returns when the key register is read.

Every unlock is good for exactly one operation. An accepted attempt sends the block back to the locked state. Any misstep sets a lockout that only the synchronous system reset clears: a wrong byte, the right bytes in the wrong order, a third key write while unlocked, or an attempt made before both keys have been seen. While lockout is set, key writes and attempts have no effect. Reads of the memory never pass through this block, so they are never gated.

Top module: `flash_keylock_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `status` is 0 (locked), `op_allow` is 0, `lockout` is 0 and `op_start` is 0.
- R2: A key write of 0xA5 in the locked state sets `status` to 1 at the next clock edge. A following key write of 0xF1 sets `status` to 2 and raises `op_allow` at the edge that samples it.
- R3: Any number of idle cycles between the two key writes leaves the unlock unaffected.
- R4: A first key write with any value other than 0xA5 sets `lockout` and makes `status` 3 at the next edge.
- R5: After 0xA5 has been accepted, a key write with any value other than 0xF1 (including a second 0xA5) sets `lockout`. A first write of 0xF1 also sets it.
- R6: A key write while unlocked (`status` 2) sets `lockout`.
- R7: An attempt while unlocked gives a single-cycle `op_start` pulse at the next edge. At that same edge `status` returns to 0 and `op_allow` to 0, so a second operation needs both keys again.
- R8: An attempt while `status` is 0 or 1 sets `lockout` at the next edge, and `op_start` stays 0.
- R9: Once set, `lockout` stays set until `rst`. While it is set, `status` reads 3, `op_allow` is 0, and key writes and attempts leave every output unchanged, with `op_start` never pulsing.
- R10: A key write in the same cycle as an attempt sets `lockout` in every state, and no `op_start` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| key_wr | input | 1 | Decoded write strobe of the key register |
| key_wdata | input | 8 | Byte written to the key register |
| op_try | input | 1 | Program or erase attempted this cycle |
| op_allow | output | 1 | An operation would be accepted now |
| op_start | output | 1 | One-cycle pulse: the attempt was accepted |
| lockout | output | 1 | Sticky lockout, cleared only by reset |
| status | output | 2 | Read code: 0 locked, 1 first key seen, 2 unlocked, 3 lockout |

## Verification
The assertions check the following on every cycle:
- lockout stays set once it is set;
- a start pulse is only ever produced for an attempt made while unlocked, and it always re-locks the sequencer;
- an attempt that is not permitted always yields lockout with no start;
- the permit level never coexists with lockout.

Only the directed scenarios can show the rest:
- which byte values and orders lead to unlock or to lockout;
- that a long pause between keys does no harm;
- that two operations each need their own key pair;
- that reset alone clears the lockout.

// File: rtl/flk_pkg.sv
package flk_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE     = 2'd0,
    SQ_KEY1_OK  = 2'd1,
    SQ_UNLOCKED = 2'd2
  } seq_state_t;

  localparam logic [1:0] STAT_LOCKED   = 2'd0;
  localparam logic [1:0] STAT_FIRST    = 2'd1;
  localparam logic [1:0] STAT_OPEN     = 2'd2;
  localparam logic [1:0] STAT_LOCKOUT  = 2'd3;

endpackage

// File: rtl/flk_key_check.sv
module flk_key_check #(
  parameter int unsigned         KEY_W      = 8,
  parameter logic [KEY_W-1:0]    KEY_FIRST  = 8'hA5,
  parameter logic [KEY_W-1:0]    KEY_SECOND = 8'hF1
) (
  input  logic [KEY_W-1:0] wdata,
  output logic             hit_first,
  output logic             hit_second
);

  always_comb begin
    hit_first  = (wdata == KEY_FIRST);
    hit_second = (wdata == KEY_SECOND);
  end

endmodule

// File: rtl/flk_seq_core.sv
module flk_seq_core
  import flk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic       hit_first,
  input  logic       hit_second,
  input  logic       op_try,
  output seq_state_t state_q,
  output logic       lockout_q,
  output logic       start_q,
  output logic       allow
);

  seq_state_t st_d;
  logic       lk_d;
  logic       start_d;

  always_comb begin
    allow = (state_q == SQ_UNLOCKED) && !lockout_q;
  end

  always_comb begin
    st_d    = state_q;
    lk_d    = lockout_q;
    start_d = 1'b0;
    if (!lockout_q) begin
      if (op_try) begin
        if (state_q == SQ_UNLOCKED && !key_wr) begin
          start_d = 1'b1;
          st_d    = SQ_IDLE;
        end else begin
          lk_d = 1'b1;
        end
      end else if (key_wr) begin
        unique case (state_q)
          SQ_IDLE:     if (hit_first)  st_d = SQ_KEY1_OK;  else lk_d = 1'b1;
          SQ_KEY1_OK:  if (hit_second) st_d = SQ_UNLOCKED; else lk_d = 1'b1;
          default:     lk_d = 1'b1;
        endcase
      end
      if (lk_d) st_d = SQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_IDLE;
      lockout_q <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      state_q   <= st_d;
      lockout_q <= lk_d;
      start_q   <= start_d;
    end
  end

  // R9: lockout is sticky until reset
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    lockout_q |=> lockout_q);

  // R7: an accepted attempt pulses start and re-locks
  p_start_relock_r7: assert property (@(posedge clk) disable iff (rst)
    (op_try && !key_wr && allow) |=> (start_q && state_q == SQ_IDLE && !allow));

  // R8: a disallowed attempt yields lockout, never a start
  p_bad_try_r8: assert property (@(posedge clk) disable iff (rst)
    (op_try && !allow) |=> (lockout_q && !start_q));

  // R10: key write together with an attempt never starts
  p_simul_r10: assert property (@(posedge clk) disable iff (rst)
    (op_try && key_wr) |=> (lockout_q && !start_q));

  // R7: start is a single-cycle pulse
  p_start_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);

endmodule

// File: rtl/flk_status_enc.sv
module flk_status_enc
  import flk_pkg::*;
(
  input  seq_state_t state_q,
  input  logic       lockout_q,
  output logic [1:0] status
);

  always_comb begin
    if (lockout_q) begin
      status = STAT_LOCKOUT;
    end else begin
      unique case (state_q)
        SQ_KEY1_OK:  status = STAT_FIRST;
        SQ_UNLOCKED: status = STAT_OPEN;
        default:     status = STAT_LOCKED;
      endcase
    end
  end

endmodule

// File: rtl/flash_keylock_seq.sv
module flash_keylock_seq
  import flk_pkg::*;
#(
  parameter int unsigned      KEY_W      = 8,
  parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hA5,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'hF1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_wdata,
  input  logic             op_try,
  output logic             op_allow,
  output logic             op_start,
  output logic             lockout,
  output logic [1:0]       status
);

  logic       hit_first;
  logic       hit_second;
  seq_state_t state_q;
  logic       lockout_q;
  logic       start_q;
  logic       allow_w;

  flk_key_check #(
    .KEY_W      (KEY_W),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_keychk (
    .wdata      (key_wdata),
    .hit_first  (hit_first),
    .hit_second (hit_second)
  );

  flk_seq_core u_core (
    .clk        (clk),
    .rst        (rst),
    .key_wr     (key_wr),
    .hit_first  (hit_first),
    .hit_second (hit_second),
    .op_try     (op_try),
    .state_q    (state_q),
    .lockout_q  (lockout_q),
    .start_q    (start_q),
    .allow      (allow_w)
  );

  flk_status_enc u_stat (
    .state_q   (state_q),
    .lockout_q (lockout_q),
    .status    (status)
  );

  assign op_allow = allow_w;
  assign op_start = start_q;
  assign lockout  = lockout_q;

  // R9: permit never coexists with lockout
  p_allow_excl_r9: assert property (@(posedge clk) disable iff (rst)
    op_allow |-> !lockout);

  // R2: permit only follows a second-key acceptance or persists while unlocked
  p_allow_origin_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(op_allow) |-> $past(status == STAT_FIRST && key_wr && !op_try));

endmodule

// File: tb/flash_keylock_seq_tb.sv
module flash_keylock_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_wr = 1'b0;
  logic [7:0] key_wdata = 8'h00;
  logic       op_try = 1'b0;
  logic       op_allow, op_start, lockout;
  logic [1:0] status;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  flash_keylock_seq u_dut (
    .clk       (clk),
    .rst       (rst),
    .key_wr    (key_wr),
    .key_wdata (key_wdata),
    .op_try    (op_try),
    .op_allow  (op_allow),
    .op_start  (op_start),
    .lockout   (lockout),
    .status    (status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; key_wr = 1'b0; op_try = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr_key(input logic [7:0] v);
    @(negedge clk); key_wr = 1'b1; key_wdata = v;
    @(negedge clk); key_wr = 1'b0;
  endtask

  task automatic attempt();
    @(negedge clk); op_try = 1'b1;
    @(negedge clk); op_try = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 status in reset", status, 0);
    chk("R1 allow in reset", op_allow, 0);
    chk("R1 lockout in reset", lockout, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 status after reset", status, 0);
    chk("R1 start after reset", op_start, 0);
  endtask

  task automatic t_unlock_op();
    do_reset();
    wr_key(8'hA5);
    chk("R2 status after first key", status, 1);
    chk("R2 allow after first key", op_allow, 0);
    wr_key(8'hF1);
    chk("R2 status after second key", status, 2);
    chk("R2 allow after second key", op_allow, 1);
    attempt();
    chk("R7 start pulse", op_start, 1);
    chk("R7 status relocked", status, 0);
    chk("R7 allow dropped", op_allow, 0);
    @(negedge clk);
    chk("R7 start single cycle", op_start, 0);
    wr_key(8'hA5); wr_key(8'hF1);
    attempt();
    chk("R7 second operation start", op_start, 1);
    attempt();
    chk("R8 attempt after relock no start", op_start, 0);
    chk("R8 attempt after relock lockout", lockout, 1);
  endtask

  task automatic t_delay();
    do_reset();
    wr_key(8'hA5);
    repeat (60) @(negedge clk);
    chk("R3 status held during pause", status, 1);
    wr_key(8'hF1);
    chk("R3 unlock after pause", status, 2);
  endtask

  task automatic t_wrong_first();
    do_reset();
    wr_key(8'h5A);
    chk("R4 lockout on wrong first", lockout, 1);
    chk("R4 status lockout code", status, 3);
    wr_key(8'hA5); wr_key(8'hF1);
    chk("R9 keys ignored status", status, 3);
    chk("R9 keys ignored allow", op_allow, 0);
    attempt();
    chk("R9 attempt no start", op_start, 0);
    repeat (3) @(negedge clk);
    chk("R9 lockout held", lockout, 1);
    do_reset();
    chk("R9 reset clears lockout", lockout, 0);
    chk("R9 reset status", status, 0);
  endtask

  task automatic t_wrong_order();
    do_reset();
    wr_key(8'hF1);
    chk("R5 second key first", status, 3);
    do_reset();
    wr_key(8'hA5); wr_key(8'hA5);
    chk("R5 first key twice", status, 3);
    do_reset();
    wr_key(8'hA5); wr_key(8'h00);
    chk("R5 bad second value", lockout, 1);
  endtask

  task automatic t_third_key();
    do_reset();
    wr_key(8'hA5); wr_key(8'hF1); wr_key(8'hA5);
    chk("R6 third key lockout", status, 3);
    attempt();
    chk("R6 no start after third key", op_start, 0);
  endtask

  task automatic t_early_try();
    do_reset();
    attempt();
    chk("R8 idle attempt lockout", lockout, 1);
    chk("R8 idle attempt no start", op_start, 0);
    do_reset();
    wr_key(8'hA5);
    attempt();
    chk("R8 half-key attempt lockout", status, 3);
    chk("R8 half-key attempt no start", op_start, 0);
  endtask

  task automatic t_simul();
    do_reset();
    wr_key(8'hA5); wr_key(8'hF1);
    @(negedge clk); key_wr = 1'b1; key_wdata = 8'hA5; op_try = 1'b1;
    @(negedge clk); key_wr = 1'b0; op_try = 1'b0;
    chk("R10 simultaneous no start", op_start, 0);
    chk("R10 simultaneous lockout", lockout, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_unlock_op();
    t_delay();
    t_wrong_first();
    t_wrong_order();
    t_third_key();
    t_early_try();
    t_simul();
    finish_run();
  end

endmodule